// File: doc/BRIEF.md
# Octave-Banded Phase-Accumulator Frequency Synthesizer

This block turns a requested output frequency into a phase-accumulator setting. The accumulator always runs in one fixed core octave, 150 MHz up to (but not including) 300 MHz, on an 800 MHz reference. The block sorts each request into one of six octave bands and shifts the request into the core octave to form a 48-bit tuning word. It then taps the accumulator at a band-dependent bit, so the core rate is divided by 8, 4 or 2, passed through, or multiplied by 2 or 4. A band below the core octave therefore gains resolution, one bit per octave, and a band above it loses resolution at the same rate.

The request `freq_req_i` is the wanted output frequency in accumulator steps, f_out * 2^48 / f_ref, where one step is about 2.84 uHz. A one-cycle `load_i` strobe starts a short sequence with four states. ST_IDLE waits for the strobe and captures the request. ST_CLASSIFY registers the band decision and the shifted tuning word. ST_APPLY commits the word and the band together. ST_REJECT raises the range error flag and keeps the old setting. Every state moves on after one cycle, except ST_IDLE, which waits. The transitions are: IDLE to CLASSIFY on a strobe; CLASSIFY to APPLY on an in-range request and to REJECT otherwise; APPLY to IDLE; REJECT to IDLE.

Top module: `ddsband_synth`

## Requirements
- R1: After reset, `ftw_o` is 0, `band_o` is 3 (the core octave), `range_err_o` is 0, and `core_clk_o` and `out_clk_o` are 0.
- R2: Band code b (0 to 4) covers requests from 3*2^(41+b) inclusive up to 3*2^(42+b) exclusive. These are 18.75, 37.5, 75, 150 and 300 MHz upward. Code 5 covers 3*2^46 (600 MHz) and up. `band_o` is never above 5.
- R3: The applied tuning word is the request shifted left by 3-b for b<3, or right by b-3 for b>=3 (floor), truncated to 48 bits. A nonzero word always lies in [3*2^44, 3*2^45).
- R4: The top band ends at 5*2^46 (1 GHz), and that value is itself accepted as band 5.
- R5: A request below 3*2^41 or above 5*2^46 sets `range_err_o` and leaves `ftw_o` and `band_o` unchanged. The next accepted request clears the flag.
- R6: The tuning word and the band change together, on the third rising edge counted from the edge that samples `load_i` (that edge included), and never at any other time.
- R7: A `load_i` strobe that arrives while a previous request is still being classified or applied is ignored.
- R8: The 51-bit accumulator adds `ftw_o` on every clock, and `core_clk_o` is its bit 47. With a word of 2^46, `core_clk_o` rises 64 times in 256 clocks.
- R9: `out_clk_o` is accumulator bit 50-b, giving core/8, /4, /2, x1, x2 and x4 for b = 0..5. With a word of 2^46 it rises 8, 32, 64 and 128 times in 256 clocks for bands 0, 2, 3 and 4.
- R10: Without a strobe, `ftw_o`, `band_o` and `range_err_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 800 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | One-cycle strobe that starts a frequency request |
| freq_req_i | input | 49 | Requested frequency in accumulator steps |
| ftw_o | output | 48 | Applied core tuning word |
| band_o | output | 3 | Applied band code, 0 (lowest) to 5 (highest) |
| range_err_o | output | 1 | Last request was out of range |
| core_clk_o | output | 1 | Accumulator MSB, the core-octave clock |
| out_clk_o | output | 1 | Band-scaled output clock |

## Verification
A wrong band decision shows on `band_o` and `ftw_o` three clocks after the strobe. It is caught by a single compare, because each band has its own shift. A wrong sequencer state shows as an update one cycle early or late, or as a second strobe that is accepted when it should be ignored, and the bench samples between those edges. A wrong accumulator width or tap point only shows in the output frequency. Counting rising edges over 256 clocks, a multiple of every period used, catches it within that window.

// File: rtl/ddsband_pkg.sv
package ddsband_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_APPLY,
        ST_REJECT
    } seq_state_t;
endpackage

// File: rtl/ddsband_classifier.sv
module ddsband_classifier #(
    parameter int ACC_W     = 48,
    parameter int NUM_BANDS = 6,
    parameter int CORE_BAND = 3,
    parameter int BAND_W    = 3
) (
    input  logic [ACC_W:0]    req_i,
    output logic [BAND_W-1:0] band_o,
    output logic              ok_o,
    output logic [ACC_W-1:0]  ftw_o
);
    localparam int REQ_W = ACC_W + 1;
    // core octave floor: 150/800 = 3/16 of full scale
    localparam logic [REQ_W-1:0] CORE_LO = REQ_W'(3) << (ACC_W - 4);
    // top cap: 1000/800 = 5/4 of full scale
    localparam logic [REQ_W-1:0] TOP_CAP = REQ_W'(5) << (ACC_W - 2);

    logic [NUM_BANDS-1:0] at_least;

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_floor
        if (b <= CORE_BAND) begin : g_low
            assign at_least[b] = req_i >= (CORE_LO >> (CORE_BAND - b));
        end else begin : g_high
            assign at_least[b] = req_i >= (CORE_LO << (b - CORE_BAND));
        end
    end

    always_comb begin
        band_o = '0;
        for (int b = 1; b < NUM_BANDS; b++) begin
            if (at_least[b]) band_o = BAND_W'(b);
        end
    end

    assign ok_o = at_least[0] && (req_i <= TOP_CAP);

    always_comb begin
        if (int'(band_o) < CORE_BAND)
            ftw_o = ACC_W'(req_i << (CORE_BAND - int'(band_o)));
        else
            ftw_o = ACC_W'(req_i >> (int'(band_o) - CORE_BAND));
    end
endmodule

// File: rtl/ddsband_ctrl.sv
module ddsband_ctrl
    import ddsband_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int CORE_BAND = 3,
    parameter int BAND_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W:0]    req_i,
    input  logic [BAND_W-1:0] cls_band_i,
    input  logic              cls_ok_i,
    input  logic [ACC_W-1:0]  cls_ftw_i,
    output logic [ACC_W:0]    req_q_o,
    output logic [ACC_W-1:0]  ftw_o,
    output logic [BAND_W-1:0] band_o,
    output logic              err_o
);
    seq_state_t state_q, state_d;
    logic [ACC_W-1:0]  dec_ftw_q;
    logic [BAND_W-1:0] dec_band_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (load_i) state_d = ST_CLASSIFY;
            ST_CLASSIFY: state_d = cls_ok_i ? ST_APPLY : ST_REJECT;
            ST_APPLY:    state_d = ST_IDLE;
            ST_REJECT:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q_o    <= '0;
            dec_ftw_q  <= '0;
            dec_band_q <= BAND_W'(CORE_BAND);
            ftw_o      <= '0;
            band_o     <= BAND_W'(CORE_BAND);
            err_o      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load_i) req_q_o <= req_i;
                end
                ST_CLASSIFY: begin
                    dec_ftw_q  <= cls_ftw_i;
                    dec_band_q <= cls_band_i;
                end
                ST_APPLY: begin
                    ftw_o  <= dec_ftw_q;
                    band_o <= dec_band_q;
                    err_o  <= 1'b0;
                end
                ST_REJECT: begin
                    err_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ddsband_accum.sv
module ddsband_accum #(
    parameter int ACC_W     = 48,
    parameter int NUM_BANDS = 6,
    parameter int CORE_BAND = 3,
    parameter int BAND_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  ftw_i,
    input  logic [BAND_W-1:0] band_i,
    output logic              core_clk_o,
    output logic              out_clk_o
);
    // extra bits above the core MSB supply the divided taps
    localparam int ACC_X   = ACC_W + CORE_BAND;
    localparam int TAP_NUM = 2 ** BAND_W;

    logic [ACC_X-1:0]   acc_q;
    logic [TAP_NUM-1:0] taps;

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + {{CORE_BAND{1'b0}}, ftw_i};
    end

    for (genvar b = 0; b < TAP_NUM; b++) begin : g_tap
        if (b < NUM_BANDS) begin : g_used
            assign taps[b] = acc_q[ACC_W - 1 + CORE_BAND - b];
        end else begin : g_spare
            assign taps[b] = 1'b0;
        end
    end

    assign core_clk_o = acc_q[ACC_W-1];
    assign out_clk_o  = taps[band_i];
endmodule

// File: rtl/ddsband_synth.sv
module ddsband_synth #(
    parameter int ACC_W     = 48,
    parameter int NUM_BANDS = 6,
    parameter int CORE_BAND = 3,
    localparam int BAND_W   = $clog2(NUM_BANDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W:0]    freq_req_i,
    output logic [ACC_W-1:0]  ftw_o,
    output logic [BAND_W-1:0] band_o,
    output logic              range_err_o,
    output logic              core_clk_o,
    output logic              out_clk_o
);
    logic [ACC_W:0]    req_q;
    logic [BAND_W-1:0] cls_band;
    logic              cls_ok;
    logic [ACC_W-1:0]  cls_ftw;

    ddsband_classifier #(
        .ACC_W(ACC_W), .NUM_BANDS(NUM_BANDS),
        .CORE_BAND(CORE_BAND), .BAND_W(BAND_W)
    ) u_cls (
        .req_i(req_q), .band_o(cls_band), .ok_o(cls_ok), .ftw_o(cls_ftw)
    );

    ddsband_ctrl #(
        .ACC_W(ACC_W), .CORE_BAND(CORE_BAND), .BAND_W(BAND_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .req_i(freq_req_i),
        .cls_band_i(cls_band), .cls_ok_i(cls_ok), .cls_ftw_i(cls_ftw),
        .req_q_o(req_q), .ftw_o(ftw_o), .band_o(band_o), .err_o(range_err_o)
    );

    ddsband_accum #(
        .ACC_W(ACC_W), .NUM_BANDS(NUM_BANDS),
        .CORE_BAND(CORE_BAND), .BAND_W(BAND_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .ftw_i(ftw_o), .band_i(band_o),
        .core_clk_o(core_clk_o), .out_clk_o(out_clk_o)
    );
endmodule

// File: rtl/ddsband_checker.sv
module ddsband_checker #(
    parameter int ACC_W     = 48,
    parameter int NUM_BANDS = 6,
    parameter int CORE_BAND = 3,
    parameter int BAND_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ACC_W-1:0]  ftw_o,
    input logic [BAND_W-1:0] band_o,
    input logic              range_err_o,
    input logic              core_clk_o,
    input logic              out_clk_o
);
    localparam logic [ACC_W-1:0] CORE_LO = ACC_W'(3) << (ACC_W - 4);
    localparam logic [ACC_W-1:0] CORE_HI = ACC_W'(3) << (ACC_W - 3);

    assert_band_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(band_o) < NUM_BANDS);

    assert_core_octave_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ftw_o != '0) |-> (ftw_o >= CORE_LO && ftw_o < CORE_HI));

    assert_reject_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(range_err_o) |-> ($stable(ftw_o) && $stable(band_o)));

    assert_update_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ftw_o) || !$stable(band_o)) |-> !range_err_o);

    assert_pass_band_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(band_o) == CORE_BAND) |-> (out_clk_o == core_clk_o));
endmodule

bind ddsband_synth ddsband_checker #(
    .ACC_W(ACC_W), .NUM_BANDS(NUM_BANDS), .CORE_BAND(CORE_BAND), .BAND_W(BAND_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ftw_o(ftw_o), .band_o(band_o),
    .range_err_o(range_err_o), .core_clk_o(core_clk_o), .out_clk_o(out_clk_o)
);

// File: tb/ddsband_synth_test.sv
`timescale 1ns/1ps
module ddsband_synth_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [48:0] req = '0;
    logic [47:0] ftw;
    logic [2:0]  band;
    logic        err, core_clk, out_clk;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ddsband_synth uut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .freq_req_i(req),
        .ftw_o(ftw), .band_o(band), .range_err_o(err),
        .core_clk_o(core_clk), .out_clk_o(out_clk)
    );

    localparam int NV = 10;
    localparam logic [48:0] V_REQ [NV] = '{
        49'd3 << 44,                  // core floor, 150 MHz
        49'd3 << 41,                  // lowest legal, 18.75 MHz
        (49'd3 << 41) - 49'd1,        // just below range
        49'd5 << 46,                  // R4 cap, 1 GHz
        (49'd5 << 46) + 49'd1,        // just above cap
        (49'd3 << 46) - 49'd1,        // just below 600 MHz
        (49'd12345 << 30) + 49'd7,    // arbitrary, band 1
        (49'd3 << 44) - 49'd1,        // just below 150 MHz
        49'd3 << 45,                  // 300 MHz exact
        49'd0                         // zero
    };
    localparam logic [47:0] V_FTW [NV] = '{
        48'd3 << 44, 48'd3 << 44, 48'd3 << 44, 48'd5 << 44, 48'd5 << 44,
        (48'd3 << 45) - 48'd1, (48'd12345 << 32) + 48'd28,
        (48'd3 << 45) - 48'd2, 48'd3 << 44, 48'd3 << 44
    };
    localparam logic [2:0] V_BAND [NV] = '{
        3'd3, 3'd0, 3'd0, 3'd5, 3'd5, 3'd4, 3'd1, 3'd2, 3'd4, 3'd4
    };
    localparam logic V_ERR [NV] = '{
        1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_req(input logic [48:0] f);
        @(negedge clk); load = 1'b1; req = f;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic count_rises(input bit use_out, input int n, output int r);
        logic prev, cur;
        r = 0;
        prev = use_out ? out_clk : core_clk;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur = use_out ? out_clk : core_clk;
            if (cur && !prev) r++;
            prev = cur;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ftw", 64'(ftw), 64'd0);
        check("R1 band", 64'(band), 64'd3);
        check("R1 err", 64'(err), 64'd0);
        check("R1 clocks", {62'd0, core_clk, out_clk}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 clocks after release", {62'd0, core_clk, out_clk}, 64'd0);

        // vector table: R2 band, R3 word, R4 cap, R5 range error
        for (int i = 0; i < NV; i++) begin
            load_req(V_REQ[i]);
            check($sformatf("R2 band vec%0d", i), 64'(band), 64'(V_BAND[i]));
            check($sformatf("R3 ftw vec%0d", i), 64'(ftw), 64'(V_FTW[i]));
            check($sformatf("R5 err vec%0d", i), 64'(err), 64'(V_ERR[i]));
        end

        // R5 error clears on the next good request (last vector left err=1)
        load_req(49'd1 << 46);
        check("R5 err cleared", 64'(err), 64'd0);
        check("R3 ftw 2^46", 64'(ftw), 64'd1 << 46);

        // R6 update timing: old value until third edge after the sampling edge
        @(negedge clk); load = 1'b1; req = 49'd1 << 47;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        check("R6 ftw not early", 64'(ftw), 64'd1 << 46);
        check("R6 band not early", 64'(band), 64'd3);
        @(negedge clk);
        check("R6 ftw on time", 64'(ftw), 64'd1 << 46);
        check("R6 band on time", 64'(band), 64'd4);

        // R7 strobe during classification ignored
        @(negedge clk); load = 1'b1; req = 49'd1 << 45;
        @(negedge clk); load = 1'b1; req = 49'd3 << 46;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        check("R7 band first wins", 64'(band), 64'd2);
        check("R7 ftw first wins", 64'(ftw), 64'd1 << 46);
        repeat (4) @(negedge clk);
        check("R7 second not applied", 64'(band), 64'd2);

        // R10 hold without strobe; R9 band 2 output rate
        count_rises(1'b1, 256, r);
        check("R9 band2 out rises", 64'(r), 64'd32);
        check("R10 ftw held", 64'(ftw), 64'd1 << 46);
        check("R10 band held", 64'(band), 64'd2);
        check("R10 err held", 64'(err), 64'd0);

        // R8 core rate, band 3
        load_req(49'd1 << 46);
        count_rises(1'b0, 256, r);
        check("R8 core rises", 64'(r), 64'd64);
        count_rises(1'b1, 256, r);
        check("R9 band3 out rises", 64'(r), 64'd64);

        // R9 band 4 (x2) and band 0 (/8), core unchanged
        load_req(49'd1 << 47);
        count_rises(1'b1, 256, r);
        check("R9 band4 out rises", 64'(r), 64'd128);
        load_req(49'd1 << 43);
        check("R2 band0 word", 64'(band), 64'd0);
        count_rises(1'b1, 256, r);
        check("R9 band0 out rises", 64'(r), 64'd8);
        count_rises(1'b0, 256, r);
        check("R8 core rises band0", 64'(r), 64'd64);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule